// File: doc/BRIEF.md
# Lock-Qualified Multi-Domain Reset Sequencer

This block produces the reset signals for a group of clock domains that are fed by a PLL. It does not trust the raw lock indication. It first brings lock into a free-running reference clock domain. There, a hold timer must see lock stay high for a set number of reference cycles without a break before it declares the clocks ready.

The ready condition is combined with the external reset and with the raw lock. The result drives two separate reset synchronizers, one in the system clock domain and one in the streaming clock domain. Each output goes into reset at once, with no clock involved. Each output leaves reset only on an edge of its own clock, so the two domains come out of reset at different moments. If lock is lost at any time, or the external reset is pulled low, both outputs return to reset immediately. After that, the whole qualification starts again.

Top module: `pll_lock_reset_seq`

## Requirements
- R1: While `ext_rst_n` is low, `sys_rst` and `strm_rst` are both high (1 = in reset), whatever the level of `pll_locked`.
- R2: After `ext_rst_n` is high and `pll_locked` rises, neither reset output goes low until `pll_locked` has stayed high for at least `HOLD_CYCLES` reference clock periods.
- R3: Once lock has been held, both reset outputs go low within a bounded latency. The bound is `HOLD_CYCLES + LOCK_STAGES + 2` reference periods plus `STAGES + 1` periods of the output's own clock.
- R4: A drop of `pll_locked` while the hold interval is running restarts the count. Release then needs a full `HOLD_CYCLES` of unbroken lock, counted from the last rising edge.
- R5: A drop of `pll_locked` after release drives both reset outputs high at once, without waiting for any clock edge. A fresh full hold interval is needed before they release again.
- R6: A falling `ext_rst_n` drives both reset outputs high at once, without waiting for any clock edge, even while lock is stable.
- R7: `sys_rst` falls only at a rising edge of `sys_clk`, and `strm_rst` falls only at a rising edge of `strm_clk`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Free-running reference clock; lock is synchronized and timed here |
| sys_clk | input | 1 | System (core) clock domain |
| strm_clk | input | 1 | Streaming clock domain |
| ext_rst_n | input | 1 | External reset, active low, asynchronous |
| pll_locked | input | 1 | Raw PLL lock indication, asynchronous |
| sys_rst | output | 1 | Reset for the system domain, active high |
| strm_rst | output | 1 | Reset for the streaming domain, active high |

## Verification
The bench measures the delay from the last rising edge of lock to each reset falling. A design that counts too little, or that freezes its counter instead of clearing it on a lock glitch, releases inside the hold window. A design that loses the ready condition never releases at all. The bench drops lock, and separately pulls the external reset, while the outputs are released. It samples within a nanosecond, so a design that asserts reset only through the synchronizer chain is caught still showing release. Every falling edge of each output is time-stamped against the last rising edge of its own clock. A release that is combinational, or that is timed by the wrong domain, lands between edges and is reported.

// File: rtl/lrs_pkg.sv
package lrs_pkg;

    typedef enum logic [1:0] {
        HOLD_IDLE  = 2'd0,
        HOLD_COUNT = 2'd1,
        HOLD_READY = 2'd2
    } hold_state_e;

    // synchronizers never go below two flops
    function automatic int unsigned sync_depth(input int unsigned req);
        return (req < 2) ? 2 : req;
    endfunction

endpackage

// File: rtl/lrs_bit_sync.sv
module lrs_bit_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic arst_n,
    input  logic d_i,
    output logic q_o
);
    localparam int unsigned N = lrs_pkg::sync_depth(STAGES);

    logic [N-1:0] pipe_d, pipe_q;

    always_comb begin
        pipe_d = {pipe_q[N-2:0], d_i};
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) pipe_q <= '0;
        else         pipe_q <= pipe_d;
    end

    assign q_o = pipe_q[N-1];

endmodule

// File: rtl/lrs_hold_timer.sv
module lrs_hold_timer #(
    parameter int unsigned HOLD_CYCLES = 1000
) (
    input  logic clk,
    input  logic arst_n,
    input  logic lock_i,
    output logic ready_o
);
    import lrs_pkg::*;

    localparam int unsigned HOLD = (HOLD_CYCLES < 1) ? 1 : HOLD_CYCLES;
    localparam int unsigned CW   = $clog2(HOLD + 1);
    localparam logic [CW-1:0] LAST = CW'(HOLD - 1);

    typedef struct packed {
        hold_state_e   st;
        logic [CW-1:0] cnt;
    } tmr_t;

    tmr_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (!lock_i) begin
            s_d.st  = HOLD_IDLE;
            s_d.cnt = '0;
        end else begin
            unique case (s_q.st)
                HOLD_IDLE: begin
                    if (HOLD == 1) begin
                        s_d.st = HOLD_READY;
                    end else begin
                        s_d.st  = HOLD_COUNT;
                        s_d.cnt = CW'(1);
                    end
                end
                HOLD_COUNT: begin
                    if (s_q.cnt == LAST) begin
                        s_d.st  = HOLD_READY;
                        s_d.cnt = '0;
                    end else begin
                        s_d.cnt = s_q.cnt + CW'(1);
                    end
                end
                HOLD_READY: s_d = s_q;
                default: begin
                    s_d.st  = HOLD_IDLE;
                    s_d.cnt = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            s_q.st  <= HOLD_IDLE;
            s_q.cnt <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign ready_o = (s_q.st == HOLD_READY);

    // R2: ready can only rise after lock was seen on consecutive edges
    p_ready_needs_lock_r2: assert property (@(posedge clk) disable iff (!arst_n)
        $rose(ready_o) |-> ($past(lock_i) && $past(s_q.st) != HOLD_IDLE));

    // R4: any lock drop clears the count and the ready state
    p_restart_on_drop_r4: assert property (@(posedge clk) disable iff (!arst_n)
        !lock_i |=> (s_q.cnt == '0 && s_q.st == HOLD_IDLE));

    // R3: the counter never runs past the hold length
    p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!arst_n)
        s_q.cnt < CW'(HOLD));

endmodule

// File: rtl/lrs_rst_sync.sv
module lrs_rst_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic arst_n,
    output logic rst_o
);
    localparam int unsigned N = lrs_pkg::sync_depth(STAGES);

    logic [N-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[N-2:0], 1'b0};
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) chain_q <= '1;
        else         chain_q <= chain_d;
    end

    assign rst_o = chain_q[N-1];

    // R7: release only follows a cycle in which the request was already high
    p_sync_release_r7: assert property (@(posedge clk) disable iff (!arst_n)
        $fell(rst_o) |-> $past(arst_n));

endmodule

// File: rtl/pll_lock_reset_seq.sv
module pll_lock_reset_seq #(
    parameter int unsigned HOLD_CYCLES = 1000,
    parameter int unsigned LOCK_STAGES = 2,
    parameter int unsigned STAGES      = 2
) (
    input  logic ref_clk,
    input  logic sys_clk,
    input  logic strm_clk,
    input  logic ext_rst_n,
    input  logic pll_locked,
    output logic sys_rst,
    output logic strm_rst
);
    logic lock_ref;
    logic ready_ref;
    logic release_n;

    lrs_bit_sync #(.STAGES(LOCK_STAGES)) u_lock_sync (
        .clk    (ref_clk),
        .arst_n (ext_rst_n),
        .d_i    (pll_locked),
        .q_o    (lock_ref)
    );

    lrs_hold_timer #(.HOLD_CYCLES(HOLD_CYCLES)) u_hold (
        .clk     (ref_clk),
        .arst_n  (ext_rst_n),
        .lock_i  (lock_ref),
        .ready_o (ready_ref)
    );

    // request goes low at once on external reset or raw lock loss
    assign release_n = ext_rst_n & pll_locked & ready_ref;

    lrs_rst_sync #(.STAGES(STAGES)) u_sys_sync (
        .clk    (sys_clk),
        .arst_n (release_n),
        .rst_o  (sys_rst)
    );

    lrs_rst_sync #(.STAGES(STAGES)) u_strm_sync (
        .clk    (strm_clk),
        .arst_n (release_n),
        .rst_o  (strm_rst)
    );

    // R5: with lock absent, both domains are held in reset
    p_lock_loss_holds_r5: assert property (@(posedge ref_clk) disable iff (!ext_rst_n)
        !pll_locked |-> (sys_rst && strm_rst));

endmodule

// File: tb/pll_lock_reset_seq_bench.sv
`timescale 1ns/1ps
module pll_lock_reset_seq_bench;

    localparam int unsigned HOLD   = 20;
    localparam int unsigned LSTG   = 2;
    localparam int unsigned STG    = 2;
    localparam real REF_P  = 5.0;
    localparam real SYS_P  = 7.0;
    localparam real STRM_P = 11.0;
    localparam real MIN_REL = HOLD * REF_P;
    localparam real MAX_SYS  = (HOLD + LSTG + 2) * REF_P + (STG + 1) * SYS_P;
    localparam real MAX_STRM = (HOLD + LSTG + 2) * REF_P + (STG + 1) * STRM_P;

    logic ref_clk = 1'b0, sys_clk = 1'b0, strm_clk = 1'b0;
    logic ext_rst_n = 1'b0, pll_locked = 1'b0;
    logic sys_rst, strm_rst;

    int tests = 0, fails = 0;
    bit finished = 1'b0;

    always #(REF_P / 2.0)  ref_clk  = ~ref_clk;
    always #(SYS_P / 2.0)  sys_clk  = ~sys_clk;
    always #(STRM_P / 2.0) strm_clk = ~strm_clk;

    pll_lock_reset_seq #(.HOLD_CYCLES(HOLD), .LOCK_STAGES(LSTG), .STAGES(STG)) u_pll_lock_reset_seq (
        .ref_clk(ref_clk), .sys_clk(sys_clk), .strm_clk(strm_clk),
        .ext_rst_n(ext_rst_n), .pll_locked(pll_locked),
        .sys_rst(sys_rst), .strm_rst(strm_rst)
    );

    // edge bookkeeping for R7
    realtime t_sys_edge = -1.0, t_strm_edge = -1.0;
    realtime t_sys_fall = -1.0, t_strm_fall = -1.0;
    int sys_async = 0, strm_async = 0;

    always @(posedge sys_clk)  t_sys_edge  = $realtime;
    always @(posedge strm_clk) t_strm_edge = $realtime;
    always @(negedge sys_rst) begin
        t_sys_fall = $realtime;
        if ($realtime != t_sys_edge) sys_async++;
    end
    always @(negedge strm_rst) begin
        t_strm_fall = $realtime;
        if ($realtime != t_strm_edge) strm_async++;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input real act, input real exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0.2f expected=%0.2f", req, what, act, exp);
        end
    endtask

    task automatic ref_cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge ref_clk);
    endtask

    // waits for both outputs low, then checks latency from t0
    task automatic check_release(input realtime t0, input string req);
        for (int i = 0; i < 200 && (sys_rst || strm_rst); i++) @(negedge ref_clk);
        #1;
        chk(!sys_rst && !strm_rst, req, "both released", real'(sys_rst | strm_rst), 0.0);
        chk(t_sys_fall - t0 >= MIN_REL, req, "sys release not early", t_sys_fall - t0, MIN_REL);
        chk(t_strm_fall - t0 >= MIN_REL, req, "strm release not early", t_strm_fall - t0, MIN_REL);
        chk(t_sys_fall - t0 <= MAX_SYS, "R3", "sys release latency", t_sys_fall - t0, MAX_SYS);
        chk(t_strm_fall - t0 <= MAX_STRM, "R3", "strm release latency", t_strm_fall - t0, MAX_STRM);
    endtask

    task automatic t_reset_state();
        pll_locked = 1'b1;
        ref_cycles(HOLD * 3);
        chk(sys_rst === 1'b1, "R1", "sys_rst held by ext reset", real'(sys_rst), 1.0);
        chk(strm_rst === 1'b1, "R1", "strm_rst held by ext reset", real'(strm_rst), 1.0);
        pll_locked = 1'b0;
        ref_cycles(4);
    endtask

    task automatic t_normal_release();
        realtime t0;
        ext_rst_n = 1'b1;
        ref_cycles(5);
        chk(sys_rst && strm_rst, "R2", "no release without lock", real'(sys_rst & strm_rst), 1.0);
        pll_locked = 1'b1;
        t0 = $realtime;
        check_release(t0, "R2");
    endtask

    task automatic t_drop_after_release();
        realtime t0;
        #1.3 pll_locked = 1'b0;
        #0.5;
        chk(sys_rst && strm_rst, "R5", "immediate assert on lock loss", real'(sys_rst & strm_rst), 1.0);
        ref_cycles(6);
        pll_locked = 1'b1;
        t0 = $realtime;
        check_release(t0, "R5");
    endtask

    task automatic t_drop_during_hold();
        realtime t0;
        pll_locked = 1'b0;
        ref_cycles(6);
        pll_locked = 1'b1;
        ref_cycles(HOLD / 2);
        chk(sys_rst && strm_rst, "R4", "still in reset mid-hold", real'(sys_rst & strm_rst), 1.0);
        pll_locked = 1'b0;
        ref_cycles(4);
        pll_locked = 1'b1;
        t0 = $realtime;
        check_release(t0, "R4");
    endtask

    task automatic t_ext_reset();
        realtime t0;
        #2.1 ext_rst_n = 1'b0;
        #0.5;
        chk(sys_rst && strm_rst, "R6", "immediate assert on ext reset", real'(sys_rst & strm_rst), 1.0);
        ref_cycles(HOLD * 2);
        chk(sys_rst && strm_rst, "R1", "held with lock high", real'(sys_rst & strm_rst), 1.0);
        ext_rst_n = 1'b1;
        t0 = $realtime;
        check_release(t0, "R6");
    endtask

    task automatic t_sync_release();
        chk(sys_async == 0, "R7", "sys_rst falls between sys_clk edges", real'(sys_async), 0.0);
        chk(strm_async == 0, "R7", "strm_rst falls between strm_clk edges", real'(strm_async), 0.0);
    endtask

    initial begin
        #1;
        t_reset_state();
        t_normal_release();
        t_drop_after_release();
        t_drop_during_hold();
        t_ext_reset();
        t_sync_release();
        if (!finished) begin
            finished = 1'b1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        #200000;
        if (!finished) begin
            finished = 1'b1;
            tests++;
            fails++;
            $display("FAIL watchdog run did not complete actual=%0d expected=0", 1);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule